// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a processor core that completes one instruction in every clock cycle. It runs a small integer subset of a classic 32-bit load/store instruction set. It has a program counter, thirty-two general registers and two small word memories inside the core: one holds instructions and one holds data. Every instruction is a 32-bit word in one of three fixed layouts: register, immediate or jump. The core decodes the word, reads its operands, computes the result and writes it back. In the same cycle it picks the next program counter.

Before execution starts, the host fills both memories through a single write port while it holds the core in reset. A retire port shows each executed instruction. It gives the program counter of the instruction and, when a register is written, the register number and the value written. A checker can follow the program from the retire port alone.

The load port uses a valid/ready handshake. A word is written in a cycle where `ld_valid` and `ld_ready` are both high. `ld_ready` is high only while `rst` is high, so any load offered while the core is running is held off and has no effect. The retire port is a plain status output. It has no back-pressure, and `ret_valid` is high in every cycle outside reset.

Top module: `rcore_top`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and clears every register. `ret_valid` stays low while `rst` is high.
- R2: The load port accepts a word only while `rst` is high (`ld_ready` = `rst`). `ld_to_data` = 0 selects instruction memory and 1 selects data memory. `ld_addr` is a word index. A load offered while the core is running changes neither memory.
- R3: Register-format words have opcode 0x00 in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, shamt in 10:6 and funct in 5:0. The core executes add (0x20), sub (0x22), and (0x24), or (0x25), nor (0x27) and signed slt (0x2A) into rd. Sums and differences wrap modulo 2^32, and slt writes 1 or 0.
- R4: sll (funct 0x00) and srl (funct 0x02) shift rt by shamt and fill the vacated bits with zeros. The result goes to rd.
- R5: addi (opcode 0x08) and slti (opcode 0x0A) use bits 15:0 widened by replicating bit 15. They write rt; slti compares as signed.
- R6: lw (opcode 0x23) loads rt from the word at rs + sign-extended offset. sw (opcode 0x2B) stores rt to that word and writes no register.
- R7: beq (opcode 0x04) is taken when rs equals rt, and bne (opcode 0x05) is taken when they differ. The target is PC+4 plus the sign-extended offset times 4. When the branch is not taken, the next PC is PC+4.
- R8: j (opcode 0x02) jumps to the upper 4 bits of PC+4, followed by bits 25:0 times 4. jr (funct 0x08) jumps to the value in rs.
- R9: Register 0 always reads as zero. A write aimed at it is dropped and is shown on the retire port with `ret_wen` low.
- R10: An unknown opcode or unknown funct acts as a no-op. It writes nothing, and the next PC is PC+4.
- R11: Outside reset, the retire port shows the PC of the instruction executing in that cycle. When a register is written, it also shows that register and the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also enables loading |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word accepted (high only during reset) |
| ld_to_data | input | 1 | 0 = instruction memory, 1 = data memory |
| ld_addr | input | LDAW | Word index of the load |
| ld_data | input | 32 | Word to load |
| ret_valid | output | 1 | An instruction executes this cycle |
| ret_pc | output | 32 | PC of the executing instruction |
| ret_wen | output | 1 | A register is written this cycle |
| ret_waddr | output | 5 | Register written |
| ret_wdata | output | 32 | Value written |

## Verification
The bench builds the core with its default 64-word instruction and data memories. That leaves room for a straight-line program that uses every operation, a store followed by a load at a positive offset, and a load at a negative offset from a preloaded word. The program also reaches a forward jump and a jump through a register into the upper half of instruction memory. Every retired PC is compared in order, so both taken and untaken branches are covered, and the program ends in a loop that branches back to itself. While that loop runs, the bench keeps offering a load aimed at the looping word. This checks that the running program is never modified.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_JMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_BNE  = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0A;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLL, ALU_SRL, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_imm;
    logic    dst_rt;
    logic    wr_en;
    logic    mem_rd;
    logic    mem_wr;
    logic    br_eq;
    logic    br_ne;
    logic    jmp;
    logic    jreg;
  } ctrl_t;

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl    = '0;
    ctl.op = ALU_ADD;
    unique case (opcode)
      OPC_REG: begin
        ctl.wr_en = 1'b1;
        unique case (funct)
          FN_ADD:  ctl.op = ALU_ADD;
          FN_SUB:  ctl.op = ALU_SUB;
          FN_AND:  ctl.op = ALU_AND;
          FN_OR:   ctl.op = ALU_OR;
          FN_NOR:  ctl.op = ALU_NOR;
          FN_SLT:  ctl.op = ALU_SLT;
          FN_SLL:  ctl.op = ALU_SLL;
          FN_SRL:  ctl.op = ALU_SRL;
          FN_JR: begin
            ctl.wr_en = 1'b0;
            ctl.jreg  = 1'b1;
          end
          default: ctl.wr_en = 1'b0;   // unknown funct: no-op
        endcase
      end
      OPC_JMP:  ctl.jmp   = 1'b1;
      OPC_BEQ:  ctl.br_eq = 1'b1;
      OPC_BNE:  ctl.br_ne = 1'b1;
      OPC_ADDI: begin
        ctl.use_imm = 1'b1; ctl.dst_rt = 1'b1; ctl.wr_en = 1'b1;
      end
      OPC_SLTI: begin
        ctl.op = ALU_SLT;
        ctl.use_imm = 1'b1; ctl.dst_rt = 1'b1; ctl.wr_en = 1'b1;
      end
      OPC_LW: begin
        ctl.use_imm = 1'b1; ctl.dst_rt = 1'b1; ctl.wr_en = 1'b1;
        ctl.mem_rd  = 1'b1;
      end
      OPC_SW: begin
        ctl.use_imm = 1'b1; ctl.mem_wr = 1'b1;
      end
      default: ;                        // unknown opcode: no-op
    endcase
  end

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int W  = XLEN,
  localparam int SW = $clog2(W)
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SW-1:0]   shamt,
  output logic [W-1:0]    y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int W     = 32,
  parameter int NREG  = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  da,
  output logic [W-1:0]  db,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign da = (ra == '0) ? '0 : regs[ra];
  assign db = (rb == '0) ? '0 : regs[rb];

  AST_ZERO_REG_HELD: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0); // R9

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW  = $clog2(IMEM_WORDS),
  localparam int DAW  = $clog2(DMEM_WORDS),
  localparam int LDAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_to_data,
  input  logic [LDAW-1:0]   ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic              ret_valid,
  output logic [XLEN-1:0]   ret_pc,
  output logic              ret_wen,
  output logic [RIDX-1:0]   ret_waddr,
  output logic [XLEN-1:0]   ret_wdata
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, pc4, pc_next, br_tgt;
  logic [XLEN-1:0] instr, simm, rs_val, rt_val, alu_b, alu_y, rd_word, wb_data;
  logic [RIDX-1:0] f_rs, f_rt, f_rd, waddr;
  logic [4:0]      f_sh;
  ctrl_t           ctl;
  logic            take, redirect, ld_fire;

  // ---------------- fetch and field split ----------------
  assign instr = imem[pc[IAW+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign simm  = {{(XLEN-16){instr[15]}}, instr[15:0]};

  rcore_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  rcore_regfile #(.W(XLEN), .NREG(32)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra  (f_rs),
    .rb  (f_rt),
    .da  (rs_val),
    .db  (rt_val),
    .we  (ret_wen),
    .wa  (waddr),
    .wd  (wb_data)
  );

  assign alu_b = ctl.use_imm ? simm : rt_val;

  rcore_alu #(.W(XLEN)) u_alu (
    .op    (ctl.op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (f_sh),
    .y     (alu_y)
  );

  // ---------------- data memory and write-back ----------------
  assign rd_word = dmem[alu_y[DAW+1:2]];
  assign wb_data = ctl.mem_rd ? rd_word : alu_y;
  assign waddr   = ctl.dst_rt ? f_rt : f_rd;

  assign ld_ready = rst;
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_to_data) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_fire && ld_to_data) dmem[ld_addr[DAW-1:0]] <= ld_data;
    end else if (ctl.mem_wr) begin
      dmem[alu_y[DAW+1:2]] <= rt_val;
    end
  end

  // ---------------- next PC ----------------
  assign pc4      = pc + 32'd4;
  assign br_tgt   = pc4 + {simm[XLEN-3:0], 2'b00};
  assign take     = (ctl.br_eq && (rs_val == rt_val)) ||
                    (ctl.br_ne && (rs_val != rt_val));
  assign redirect = take || ctl.jmp || ctl.jreg;

  always_comb begin
    if (ctl.jreg)     pc_next = rs_val;
    else if (ctl.jmp) pc_next = {pc4[31:28], instr[25:0], 2'b00};
    else if (take)    pc_next = br_tgt;
    else              pc_next = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  // ---------------- retire port ----------------
  assign ret_valid = !rst;
  assign ret_pc    = pc;
  assign ret_wen   = !rst && ctl.wr_en && (waddr != '0);
  assign ret_waddr = waddr;
  assign ret_wdata = wb_data;

  // ---------------- assertions ----------------
  AST_RESET_PC_ZERO: assert property (@(posedge clk)
    rst |=> (pc == '0)); // R1

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (pc == $past(pc) + 32'd4)); // R10

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    take |=> (pc == $past(pc) + 32'd4 + {$past(simm[XLEN-3:0]), 2'b00})); // R7

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    ctl.jmp |=> (pc[31:28] == $past(pc4[31:28]))); // R8

  AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.br_eq, ctl.br_ne, ctl.jmp, ctl.jreg})); // R8

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ctl.mem_rd && ctl.mem_wr)); // R6

  AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (rst)
    (ctl.op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0)); // R3

endmodule

// File: tb/test_rcore_top.sv
module test_rcore_top;

  localparam int LDAW = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid, ld_ready, ld_to_data;
  logic [LDAW-1:0] ld_addr;
  logic [31:0] ld_data;
  logic        ret_valid, ret_wen;
  logic [31:0] ret_pc, ret_wdata;
  logic [4:0]  ret_waddr;

  always #2 clk = ~clk;   // 250 MHz

  rcore_top i_rcore_top (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_to_data(ld_to_data),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_wen(ret_wen),
    .ret_waddr(ret_waddr), .ret_wdata(ret_wdata)
  );

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] pc;
    logic        wen;
    logic [4:0]  wa;
    logic [31:0] wd;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  bit   mon_on = 1'b0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, int idx);
    return {op, idx[25:0]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [31:0] pc, logic wen, int wa, logic [31:0] wd, string req);
    exp_t e;
    e.pc = pc; e.wen = wen; e.wa = wa[4:0]; e.wd = wd; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pop one expected item per retired instruction
  always @(negedge clk) begin
    if (mon_on && ret_valid && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(ret_pc == e.pc, e.req, "retire pc", ret_pc, e.pc);
      check(ret_wen == e.wen, e.req, "retire wen", {31'b0, ret_wen}, {31'b0, e.wen});
      if (e.wen) begin
        check(ret_waddr == e.wa, e.req, "retire waddr", {27'b0, ret_waddr}, {27'b0, e.wa});
        check(ret_wdata == e.wd, e.req, "retire wdata", ret_wdata, e.wd);
      end
    end
  end

  logic [31:0] prog [34];
  int cyc = 0;
  bit timeout = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 4000 && !timeout) timeout <= 1'b1;
  end

  initial begin
    rst = 1'b1; ld_valid = 1'b0; ld_to_data = 1'b0; ld_addr = '0; ld_data = '0;

    prog[0]  = enc_i(6'h08, 0, 1, 5);          // addi r1 = 5
    prog[1]  = enc_i(6'h08, 0, 2, -8);         // addi r2 = -8
    prog[2]  = enc_r(1, 2, 3, 0, 6'h20);       // add
    prog[3]  = enc_r(1, 2, 4, 0, 6'h22);       // sub
    prog[4]  = enc_r(1, 2, 5, 0, 6'h24);       // and
    prog[5]  = enc_r(1, 2, 6, 0, 6'h25);       // or
    prog[6]  = enc_r(1, 0, 7, 0, 6'h27);       // nor
    prog[7]  = enc_r(2, 1, 8, 0, 6'h2A);       // slt
    prog[8]  = enc_i(6'h0A, 1, 9, -1);         // slti
    prog[9]  = enc_r(0, 1, 10, 4, 6'h00);      // sll
    prog[10] = enc_r(0, 2, 11, 28, 6'h02);     // srl
    prog[11] = enc_i(6'h2B, 10, 3, 8);         // sw r3, 8(r10)
    prog[12] = enc_i(6'h23, 10, 12, 8);        // lw r12, 8(r10)
    prog[13] = enc_i(6'h23, 10, 13, -8);       // lw r13, -8(r10)
    prog[14] = enc_i(6'h08, 1, 0, 7);          // addi r0 (dropped)
    prog[15] = enc_r(0, 0, 14, 0, 6'h20);      // add r14 = r0 + r0
    prog[16] = 32'hFC00_0000;                  // unknown opcode
    prog[17] = enc_r(1, 2, 20, 0, 6'h3F);      // unknown funct
    prog[18] = enc_r(7, 11, 16, 0, 6'h20);     // add with wrap
    prog[19] = enc_i(6'h04, 1, 2, 5);          // beq not taken
    prog[20] = enc_i(6'h05, 1, 2, 2);          // bne taken -> 0x5C
    prog[21] = enc_i(6'h08, 0, 17, 1);
    prog[22] = enc_i(6'h08, 0, 17, 2);
    prog[23] = enc_i(6'h04, 9, 0, 1);          // beq taken -> 0x64
    prog[24] = enc_i(6'h08, 0, 17, 3);
    prog[25] = enc_j(6'h02, 32'h1C);           // j 0x70
    prog[26] = enc_i(6'h08, 0, 17, 4);
    prog[27] = enc_i(6'h08, 0, 17, 4);
    prog[28] = enc_i(6'h08, 0, 18, 32'h80);    // r18 = 0x80
    prog[29] = enc_r(18, 0, 0, 0, 6'h08);      // jr r18
    prog[30] = enc_i(6'h08, 0, 17, 5);
    prog[31] = enc_i(6'h08, 0, 17, 5);
    prog[32] = enc_i(6'h05, 1, 1, 3);          // bne not taken
    prog[33] = enc_i(6'h04, 0, 0, -1);         // beq to self

    @(posedge clk); #1;
    @(negedge clk);
    check(ret_valid == 1'b0, "R1", "ret_valid in reset", {31'b0, ret_valid}, 32'h0);
    check(ld_ready == 1'b1, "R2", "ld_ready in reset", {31'b0, ld_ready}, 32'h1);

    for (int i = 0; i < 34; i++) begin
      @(posedge clk); #1;
      ld_valid = 1'b1; ld_to_data = 1'b0; ld_addr = i[LDAW-1:0]; ld_data = prog[i];
    end
    @(posedge clk); #1;
    ld_to_data = 1'b1; ld_addr = 6'd18; ld_data = 32'hCAFE_F00D;
    @(posedge clk); #1;
    ld_valid = 1'b0;

    push(32'h00, 1, 1,  32'h5,         "R5");
    push(32'h04, 1, 2,  32'hFFFF_FFF8, "R5");
    push(32'h08, 1, 3,  32'hFFFF_FFFD, "R3");
    push(32'h0C, 1, 4,  32'h0000_000D, "R3");
    push(32'h10, 1, 5,  32'h0,         "R3");
    push(32'h14, 1, 6,  32'hFFFF_FFFD, "R3");
    push(32'h18, 1, 7,  32'hFFFF_FFFA, "R3");
    push(32'h1C, 1, 8,  32'h1,         "R3");
    push(32'h20, 1, 9,  32'h0,         "R5");
    push(32'h24, 1, 10, 32'h50,        "R4");
    push(32'h28, 1, 11, 32'hF,         "R4");
    push(32'h2C, 0, 0,  32'h0,         "R6");
    push(32'h30, 1, 12, 32'hFFFF_FFFD, "R6");
    push(32'h34, 1, 13, 32'hCAFE_F00D, "R6");
    push(32'h38, 0, 0,  32'h0,         "R9");
    push(32'h3C, 1, 14, 32'h0,         "R9");
    push(32'h40, 0, 0,  32'h0,         "R10");
    push(32'h44, 0, 0,  32'h0,         "R10");
    push(32'h48, 1, 16, 32'h9,         "R3");
    push(32'h4C, 0, 0,  32'h0,         "R7");
    push(32'h50, 0, 0,  32'h0,         "R7");
    push(32'h5C, 0, 0,  32'h0,         "R7");
    push(32'h64, 0, 0,  32'h0,         "R7");
    push(32'h70, 1, 18, 32'h80,        "R8");
    push(32'h74, 0, 0,  32'h0,         "R8");
    push(32'h80, 0, 0,  32'h0,         "R8");
    for (int k = 0; k < 6; k++) push(32'h84, 0, 0, 32'h0, "R2");

    // leave reset; keep offering a load onto the looping word (must be ignored)
    @(posedge clk); #1;
    rst = 1'b0; mon_on = 1'b1;
    ld_valid = 1'b1; ld_to_data = 1'b0; ld_addr = 6'd33;
    ld_data = enc_i(6'h08, 0, 19, 1);
    @(negedge clk);
    check(ld_ready == 1'b0, "R2", "ld_ready running", {31'b0, ld_ready}, 32'h0);
    check(ret_valid == 1'b1, "R11", "ret_valid running", {31'b0, ret_valid}, 32'h1);
    check(ret_pc == 32'h0, "R1", "pc after reset", ret_pc, 32'h0);

    while (exp_q.size() > 0 && !timeout) @(posedge clk);
    ld_valid = 1'b0;
    if (timeout) check(1'b0, "R11", "watchdog expired", 32'h0, 32'h1);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule